// File: doc/BRIEF.md
# Selective Zero-Suppression Input Channel

This block sits on one input of a data concentrator and handles the event fragment of a single 25-crystal readout tower. Each crystal contributes 10 time samples. The samples arrive as one word per valid cycle, crystal by crystal. Before the tower's first sample, an external selective-readout stage sends a 2-bit readout mode for the tower. The mode tells the block to drop the whole tower, to keep every crystal, or to keep only the crystals whose filtered amplitude passes a threshold.

For the filtered mode, the block accumulates a signed weighted sum over a crystal's 10 samples while they arrive. It holds the samples in a two-bank buffer. When the last sample is in, the block decides whether to keep the crystal. A kept crystal is then replayed on the output stream as 10 consecutive beats, each tagged with its crystal index. The next crystal fills the other bank during the replay. After the last crystal of a tower, a one-cycle end-of-tower pulse carries the number of crystals kept. Two one-cycle flags report an illegal mode code and a tower that started without a mode.

Top module: `zs_input_channel`

## Requirements
- R1: Mode code 2'b00 (drop): no output beat is produced for the tower, and its end-of-tower count is 0.
- R2: Mode code 2'b10 (full): every crystal of the tower is output, and the end-of-tower count equals the crystal count (25).
- R3: Mode code 2'b01 (filtered): a crystal is kept exactly when sum over j of w[j]*s[j] >= threshold. The weights are signed 12-bit values; weight j sits at bits [12j+11:12j] of `weights_i`. The samples are unsigned 12-bit values, and the threshold is a signed 29-bit value. A sum equal to the threshold is kept.
- R4: Kept crystals leave in input order. Each one gives 10 beats carrying its samples in arrival order, and every beat shows that crystal's index (0..24).
- R5: Beat 0 of a kept crystal is visible in the cycle after the clock edge that captures its 10th sample. The remaining beats follow on consecutive cycles, whatever idle input cycles occur.
- R6: `eot_valid_o` pulses for one cycle, in the cycle after the edge that captures the tower's last sample. `eot_count_o` then equals the number of crystals kept in that tower.
- R7: Mode code 2'b11 reads the tower in full. `err_code_o` pulses for one cycle, in the cycle after the edge that captures the tower's first sample.
- R8: A mode must be captured in a cycle strictly before the tower's first sample. If it is not, the tower is read in full and `err_nomode_o` pulses in the cycle after the first sample's edge. A mode given in the same cycle as a first sample is held for the next tower.
- R9: After reset, `out_valid_o`, `eot_valid_o`, `err_code_o` and `err_nomode_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_valid_i | input | 1 | Readout mode strobe for the next tower |
| mode_i | input | 2 | Readout mode code |
| samp_valid_i | input | 1 | Sample strobe |
| samp_i | input | 12 | Unsigned time sample |
| weights_i | input | 120 | Ten signed 12-bit filter weights |
| thresh_i | input | 29 | Signed keep threshold |
| out_valid_o | output | 1 | Output beat valid |
| out_xtal_o | output | 5 | Crystal index of the beat |
| out_data_o | output | 12 | Sample carried by the beat |
| eot_valid_o | output | 1 | End-of-tower pulse |
| eot_count_o | output | 5 | Kept-crystal count of the tower |
| err_code_o | output | 1 | Illegal mode code seen |
| err_nomode_o | output | 1 | Tower started with no mode |

## Verification
Each result has a fixed cycle, set by the edge that captures a given sample. Output beat b of a crystal is due in the cycle after that crystal's 10th-sample edge, plus b. The end-of-tower pulse is due in the cycle after the tower's last-sample edge. The error flags are due in the cycle after the first-sample edge. The bench reads its own cycle counter at each falling edge while it drives a sample, and queues every expected beat, count and flag with the exact cycle it is due in. At each falling edge it compares the outputs both in value and in cycle, so a result that is late, early or extra counts as a mismatch.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    MODE_DROP = 2'b00,
    MODE_ZS   = 2'b01,
    MODE_FULL = 2'b10,
    MODE_BAD  = 2'b11
  } rd_mode_e;
endpackage

// File: rtl/zs_fir_acc.sv
module zs_fir_acc #(
  parameter int N_SAMP = 10,
  parameter int SAMP_W = 12,
  parameter int COEF_W = 12,
  parameter int SIDX_W = 4,
  parameter int ACC_W  = 29
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       samp_valid_i,
  input  logic [SAMP_W-1:0]          samp_i,
  input  logic [SIDX_W-1:0]          samp_idx_i,
  input  logic [N_SAMP*COEF_W-1:0]   weights_i,
  output logic signed [ACC_W-1:0]    sum_o
);
  localparam int PROD_W = COEF_W + SAMP_W + 1;

  logic signed [COEF_W-1:0] w_arr [N_SAMP];
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_q;

  for (genvar g = 0; g < N_SAMP; g++) begin : g_w
    assign w_arr[g] = weights_i[g*COEF_W +: COEF_W];
  end

  assign prod  = PROD_W'(w_arr[samp_idx_i]) * PROD_W'($signed({1'b0, samp_i}));
  // running sum restarts on the first sample of each crystal
  assign sum_o = ((samp_idx_i == '0) ? '0 : acc_q) + ACC_W'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_q <= '0;
    else if (samp_valid_i) acc_q <= sum_o;
  end
endmodule

// File: rtl/zs_tower_ctrl.sv
module zs_tower_ctrl
  import zs_pkg::*;
#(
  parameter int N_SAMP = 10,
  parameter int N_XTAL = 25,
  parameter int ACC_W  = 29,
  parameter int SIDX_W = 4,
  parameter int XIDX_W = 5,
  parameter int CNT_W  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_valid_i,
  input  logic [1:0]              mode_i,
  input  logic                    samp_valid_i,
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic [ACC_W-1:0]        thresh_i,
  output logic [SIDX_W-1:0]       samp_idx_o,
  output logic [XIDX_W-1:0]       xtal_idx_o,
  output logic                    xtal_done_o,
  output logic                    keep_o,
  output rd_mode_e                mode_o,
  output logic                    eot_valid_o,
  output logic [CNT_W-1:0]        eot_count_o,
  output logic                    err_code_o,
  output logic                    err_nomode_o
);
  logic [SIDX_W-1:0] samp_idx_q;
  logic [XIDX_W-1:0] xtal_idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q;
  rd_mode_e          pend_mode_q, tower_mode_q, first_mode;
  logic              last_s, last_x, first_smp;

  assign last_s      = samp_idx_q == SIDX_W'(N_SAMP - 1);
  assign last_x      = xtal_idx_q == XIDX_W'(N_XTAL - 1);
  assign first_smp   = samp_valid_i && (samp_idx_q == '0) && (xtal_idx_q == '0);
  assign xtal_done_o = samp_valid_i && last_s;
  assign samp_idx_o  = samp_idx_q;
  assign xtal_idx_o  = xtal_idx_q;
  assign mode_o      = tower_mode_q;

  always_comb begin
    if (!pend_q || pend_mode_q == MODE_BAD) first_mode = MODE_FULL;
    else                                    first_mode = pend_mode_q;
  end

  assign keep_o = xtal_done_o &&
                  ((tower_mode_q == MODE_FULL) ||
                   ((tower_mode_q == MODE_ZS) && (sum_i >= $signed(thresh_i))));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_idx_q <= '0;
      xtal_idx_q <= '0;
    end else if (samp_valid_i) begin
      if (last_s) begin
        samp_idx_q <= '0;
        xtal_idx_q <= last_x ? '0 : xtal_idx_q + 1'b1;
      end else begin
        samp_idx_q <= samp_idx_q + 1'b1;
      end
    end
  end

  // a mode strobed with a first sample belongs to the following tower
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_mode_q  <= MODE_FULL;
      tower_mode_q <= MODE_FULL;
      err_code_o   <= 1'b0;
      err_nomode_o <= 1'b0;
    end else begin
      err_code_o   <= first_smp && pend_q && (pend_mode_q == MODE_BAD);
      err_nomode_o <= first_smp && !pend_q;
      if (first_smp) tower_mode_q <= first_mode;
      if (mode_valid_i) begin
        pend_q      <= 1'b1;
        pend_mode_q <= rd_mode_e'(mode_i);
      end else if (first_smp) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      eot_valid_o <= 1'b0;
      eot_count_o <= '0;
    end else begin
      eot_valid_o <= xtal_done_o && last_x;
      if (xtal_done_o) begin
        if (last_x) begin
          cnt_q       <= '0;
          eot_count_o <= cnt_q + CNT_W'(keep_o);
        end else begin
          cnt_q <= cnt_q + CNT_W'(keep_o);
        end
      end
    end
  end

  p_eot_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_valid_o |-> (eot_count_o <= CNT_W'(N_XTAL)));

  p_eot_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_valid_o |=> !eot_valid_o);

  p_drop_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_valid_o && tower_mode_q == MODE_DROP) |-> (eot_count_o == '0));

  p_code_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_code_o |=> !err_code_o);

  p_nomode_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_nomode_o |=> !err_nomode_o);
endmodule

// File: rtl/zs_xtal_buf.sv
module zs_xtal_buf #(
  parameter int N_SAMP = 10,
  parameter int SAMP_W = 12,
  parameter int SIDX_W = 4,
  parameter int XIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_valid_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [SIDX_W-1:0] samp_idx_i,
  input  logic              xtal_done_i,
  input  logic              keep_i,
  input  logic [XIDX_W-1:0] xtal_idx_i,
  output logic              out_valid_o,
  output logic [XIDX_W-1:0] out_xtal_o,
  output logic [SAMP_W-1:0] out_data_o
);
  localparam int MEM_N = 2 ** (SIDX_W + 1);

  logic [SAMP_W-1:0] mem_q [MEM_N];
  logic              wr_bank_q, rd_bank_q, act_q;
  logic [SIDX_W-1:0] beat_q;
  logic [XIDX_W-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (samp_valid_i) mem_q[{wr_bank_q, samp_idx_i}] <= samp_i;
  end

  // bank written by the next crystal is never the one being replayed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
      act_q     <= 1'b0;
      beat_q    <= '0;
      idx_q     <= '0;
    end else if (xtal_done_i) begin
      wr_bank_q <= ~wr_bank_q;
      rd_bank_q <= wr_bank_q;
      act_q     <= keep_i;
      beat_q    <= '0;
      idx_q     <= xtal_idx_i;
    end else if (act_q) begin
      if (beat_q == SIDX_W'(N_SAMP - 1)) act_q <= 1'b0;
      else                               beat_q <= beat_q + 1'b1;
    end
  end

  assign out_valid_o = act_q;
  assign out_xtal_o  = idx_q;
  assign out_data_o  = mem_q[{rd_bank_q, beat_q}];

  p_burst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && beat_q != SIDX_W'(N_SAMP - 1)) |=> act_q);

  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtal_done_i |-> (!act_q || beat_q == SIDX_W'(N_SAMP - 1)));
endmodule

// File: rtl/zs_input_channel.sv
module zs_input_channel
  import zs_pkg::*;
#(
  parameter int N_SAMP = 10,
  parameter int N_XTAL = 25,
  parameter int SAMP_W = 12,
  parameter int COEF_W = 12,
  localparam int SIDX_W = $clog2(N_SAMP),
  localparam int XIDX_W = $clog2(N_XTAL),
  localparam int CNT_W  = $clog2(N_XTAL + 1),
  localparam int ACC_W  = COEF_W + SAMP_W + 1 + $clog2(N_SAMP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode_valid_i,
  input  logic [1:0]               mode_i,
  input  logic                     samp_valid_i,
  input  logic [SAMP_W-1:0]        samp_i,
  input  logic [N_SAMP*COEF_W-1:0] weights_i,
  input  logic [ACC_W-1:0]         thresh_i,
  output logic                     out_valid_o,
  output logic [XIDX_W-1:0]        out_xtal_o,
  output logic [SAMP_W-1:0]        out_data_o,
  output logic                     eot_valid_o,
  output logic [CNT_W-1:0]         eot_count_o,
  output logic                     err_code_o,
  output logic                     err_nomode_o
);
  logic signed [ACC_W-1:0] sum;
  logic [SIDX_W-1:0]       samp_idx;
  logic [XIDX_W-1:0]       xtal_idx;
  logic                    xtal_done, keep;
  rd_mode_e                tower_mode;

  zs_tower_ctrl #(
    .N_SAMP(N_SAMP), .N_XTAL(N_XTAL), .ACC_W(ACC_W),
    .SIDX_W(SIDX_W), .XIDX_W(XIDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .mode_valid_i, .mode_i, .samp_valid_i,
    .sum_i(sum), .thresh_i,
    .samp_idx_o(samp_idx), .xtal_idx_o(xtal_idx), .xtal_done_o(xtal_done),
    .keep_o(keep), .mode_o(tower_mode),
    .eot_valid_o, .eot_count_o, .err_code_o, .err_nomode_o
  );

  zs_fir_acc #(
    .N_SAMP(N_SAMP), .SAMP_W(SAMP_W), .COEF_W(COEF_W),
    .SIDX_W(SIDX_W), .ACC_W(ACC_W)
  ) u_fir (
    .clk_i, .rst_ni, .samp_valid_i, .samp_i, .samp_idx_i(samp_idx),
    .weights_i, .sum_o(sum)
  );

  zs_xtal_buf #(
    .N_SAMP(N_SAMP), .SAMP_W(SAMP_W), .SIDX_W(SIDX_W), .XIDX_W(XIDX_W)
  ) u_buf (
    .clk_i, .rst_ni, .samp_valid_i, .samp_i, .samp_idx_i(samp_idx),
    .xtal_done_i(xtal_done), .keep_i(keep), .xtal_idx_i(xtal_idx),
    .out_valid_o, .out_xtal_o, .out_data_o
  );

  p_drop_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtal_done && tower_mode == MODE_DROP) |=> !out_valid_o);

  p_full_emit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xtal_done && tower_mode == MODE_FULL) |=> (out_valid_o && out_xtal_o == $past(xtal_idx)));
endmodule

// File: tb/zs_input_channel_test.sv
module zs_input_channel_test;
  localparam int NS = 10;
  localparam int NX = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        samp_valid = 1'b0;
  logic [11:0] samp = '0;
  logic [119:0] weights = '0;
  logic [28:0] thresh = '0;
  logic        out_valid, eot_valid, err_code, err_nomode;
  logic [4:0]  out_xtal, eot_count;
  logic [11:0] out_data;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int w [NS];

  int q_idx[$], q_dat[$], q_cyc[$];
  int q_eot_cnt[$], q_eot_cyc[$];
  int q_code_cyc[$], q_nom_cyc[$];

  zs_input_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_valid_i(mode_valid), .mode_i(mode),
    .samp_valid_i(samp_valid), .samp_i(samp), .weights_i(weights), .thresh_i(thresh),
    .out_valid_o(out_valid), .out_xtal_o(out_xtal), .out_data_o(out_data),
    .eot_valid_o(eot_valid), .eot_count_o(eot_count),
    .err_code_o(err_code), .err_nomode_o(err_nomode)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int samp_of(input int seed, input int x, input int j);
    return (seed * 977 + x * 131 + j * 37 + x * x * j * 7) % 4096;
  endfunction

  function automatic int sum_of(input int seed, input int x);
    int s = 0;
    for (int j = 0; j < NS; j++) s += w[j] * samp_of(seed, x, j);
    return s;
  endfunction

  task automatic set_weights(input int a0, input int a1, input int a2, input int a3, input int a4,
                             input int a5, input int a6, input int a7, input int a8, input int a9);
    w[0] = a0; w[1] = a1; w[2] = a2; w[3] = a3; w[4] = a4;
    w[5] = a5; w[6] = a6; w[7] = a7; w[8] = a8; w[9] = a9;
    for (int j = 0; j < NS; j++) weights[j*12 +: 12] = 12'(w[j]);
  endtask

  // how: 0 no mode, 1 mode one cycle ahead, 2 mode with first sample
  // eff: 0 drop, 1 filtered, 2 full
  task automatic run_tower(input int how, input logic [1:0] code, input int eff, input int thr,
                           input int seed, input bit gaps, input bit exp_code, input bit exp_nom);
    int kept = 0;
    thresh = 29'(thr);
    if (how == 1) begin
      @(negedge clk); mode_valid = 1'b1; mode = code;
      @(negedge clk); mode_valid = 1'b0;
    end
    for (int x = 0; x < NX; x++) begin
      bit keep;
      keep = (eff == 2) || (eff == 1 && sum_of(seed, x) >= thr);
      for (int j = 0; j < NS; j++) begin
        if (!(x == 0 && j == 0) || how != 1) @(negedge clk);
        samp_valid = 1'b1;
        samp = 12'(samp_of(seed, x, j));
        if (x == 0 && j == 0) begin
          if (how == 2) begin mode_valid = 1'b1; mode = code; end
          if (exp_code) q_code_cyc.push_back(cyc + 1);
          if (exp_nom)  q_nom_cyc.push_back(cyc + 1);
        end
        if (j == NS - 1 && keep) begin
          for (int b = 0; b < NS; b++) begin
            q_idx.push_back(x); q_dat.push_back(samp_of(seed, x, b)); q_cyc.push_back(cyc + 1 + b);
          end
        end
        if (j == NS - 1 && keep) kept++;
        if (x == NX - 1 && j == NS - 1) begin
          q_eot_cnt.push_back(kept); q_eot_cyc.push_back(cyc + 1);
        end
        if (x == 0 && j == 0 && how == 2) begin
          @(negedge clk); mode_valid = 1'b0;
          samp_valid = 1'b0;
          // second sample follows in the next loop pass
        end
      end
      if (gaps && x[0]) begin
        @(negedge clk); samp_valid = 1'b0;
        @(negedge clk);
      end
    end
    @(negedge clk); samp_valid = 1'b0;
    repeat (14) @(negedge clk);
    chk(q_idx.size() == 0, "R4 all kept beats delivered", q_idx.size(), 0);
    chk(q_eot_cnt.size() == 0, "R6 end marker delivered", q_eot_cnt.size(), 0);
    chk(q_code_cyc.size() == 0, "R7 code flag delivered", q_code_cyc.size(), 0);
    chk(q_nom_cyc.size() == 0, "R8 missing-mode flag delivered", q_nom_cyc.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_idx.size() == 0) chk(1'b0, "R1/R3 unexpected beat", int'(out_xtal), -1);
        else begin
          int ei, ed, ec;
          ei = q_idx.pop_front(); ed = q_dat.pop_front(); ec = q_cyc.pop_front();
          chk(int'(out_xtal) == ei, "R4 crystal index", int'(out_xtal), ei);
          chk(int'(out_data) == ed, "R4 sample value", int'(out_data), ed);
          chk(cyc == ec, "R5 beat cycle", cyc, ec);
        end
      end
      if (eot_valid) begin
        if (q_eot_cnt.size() == 0) chk(1'b0, "R6 unexpected end marker", int'(eot_count), -1);
        else begin
          int en, ec;
          en = q_eot_cnt.pop_front(); ec = q_eot_cyc.pop_front();
          chk(int'(eot_count) == en, "R6 kept count", int'(eot_count), en);
          chk(cyc == ec, "R6 end marker cycle", cyc, ec);
        end
      end
      if (err_code) begin
        if (q_code_cyc.size() == 0) chk(1'b0, "R7 unexpected code flag", cyc, -1);
        else begin
          int ec;
          ec = q_code_cyc.pop_front();
          chk(cyc == ec, "R7 code flag cycle", cyc, ec);
        end
      end
      if (err_nomode) begin
        if (q_nom_cyc.size() == 0) chk(1'b0, "R8 unexpected missing-mode flag", cyc, -1);
        else begin
          int ec;
          ec = q_nom_cyc.pop_front();
          chk(cyc == ec, "R8 missing-mode flag cycle", cyc, ec);
        end
      end
    end
  end

  initial begin
    int thr_b;
    set_weights(5, -4, 3, -2, 1, 1, -2, 3, -4, 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R9 out_valid after reset", int'(out_valid), 0);
    chk(!eot_valid, "R9 eot_valid after reset", int'(eot_valid), 0);
    chk(!err_code && !err_nomode, "R9 flags after reset", int'(err_code) + int'(err_nomode), 0);

    run_tower(1, 2'b10, 2, 0, 1, 1'b0, 1'b0, 1'b0);           // R2 full
    run_tower(1, 2'b00, 0, 0, 2, 1'b0, 1'b0, 1'b0);           // R1 drop
    run_tower(1, 2'b01, 1, 0, 3, 1'b1, 1'b0, 1'b0);           // R3 filtered, gaps (R5)
    thr_b = sum_of(4, 3);
    run_tower(1, 2'b01, 1, thr_b, 4, 1'b0, 1'b0, 1'b0);       // R3 equal is kept
    run_tower(1, 2'b01, 1, thr_b + 1, 4, 1'b0, 1'b0, 1'b0);   // R3 one above
    run_tower(1, 2'b11, 2, 0, 5, 1'b0, 1'b1, 1'b0);           // R7
    run_tower(0, 2'b00, 2, 0, 6, 1'b0, 1'b0, 1'b1);           // R8 no mode
    run_tower(2, 2'b01, 2, 0, 7, 1'b0, 1'b0, 1'b1);           // R8 late mode: full now
    run_tower(0, 2'b00, 1, 0, 8, 1'b1, 1'b0, 1'b0);           // R8 late mode used here
    set_weights(-2048, 2047, -1, 0, 7, -300, 11, 2047, -2048, 1);
    run_tower(1, 2'b01, 1, -268435456, 9, 1'b0, 1'b0, 1'b0);  // R3 all pass
    run_tower(1, 2'b01, 1, 500, 10, 1'b1, 1'b0, 1'b0);        // R3 signed weights
    run_tower(1, 2'b01, 1, 268435455, 11, 1'b0, 1'b0, 1'b0);  // R3 none pass

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule